// File: doc/BRIEF.md
# Programmable Almost-Empty / Almost-Full Flag Unit

This block produces the almost-empty and almost-full levels for a FIFO whose write and read sides run on separate clocks. It takes the binary write pointer, which lives in the write clock domain, and the binary read pointer, which lives in the read clock domain. Each pointer has one wrap bit above the address bits. The pointers cross to the opposite domain as Gray code. Each side then compares its own view of the fill level against two programmable thresholds.

While master reset is held, the block samples its configuration pins. A three-bit index picks a default threshold pair, with the program-select pin as the top bit and the two default-select pins below it. A timing pin selects how the flags are clocked. A parity pin selects where the parity bits sit in the 18-bit programming word. In synchronous timing, each flag is a register in one clock domain. In asynchronous timing, each flag is set by the clock of the side that drains towards it and released by the other clock.

After reset, pulling the program-select pin low turns the write and read strobes into accesses to the threshold pair. These accesses alternate between the empty threshold and the full threshold.

Top module: `prog_level_flags`

## Requirements
- R1: While master reset is held and just after it is released with both pointers at zero, `almost_empty` is 1, `almost_full` is 0 and `prog_dout` is 0.
- R2: The default value of both thresholds is 2^(k+3)-1, where k = 4*prog_n + 2*dflt_sel[1] + dflt_sel[0] is sampled during reset. This gives 7, 15, 31, 63, 127, 255, 511 or 1023.
- R3: With occupancy = (wr_ptr - rd_ptr) modulo 2^(AW+1), `almost_empty` settles to 1 exactly when occupancy <= empty threshold.
- R4: With free = 2^AW - occupancy, `almost_full` settles to 1 exactly when free <= full threshold.
- R5: With `flag_sync_sel` = 1 at reset, `almost_empty` changes only on `rclk` edges and `almost_full` changes only on `wclk` edges. With `rclk` stopped, `almost_empty` stays put; with `wclk` stopped, `almost_full` stays put.
- R6: With `flag_sync_sel` = 0 at reset, `almost_empty` is set on `rclk` and released on `wclk`, and `almost_full` is set on `wclk` and released on `rclk`. Each flag can therefore release while the clock that sets it is stopped.
- R7: A `wclk` edge with `prog_n` = 0 and `wr_stb` = 1 writes the empty threshold first and the full threshold next, then wraps back to the empty threshold. The sequence restarts at the empty threshold after every master reset.
- R8: An `rclk` edge with `prog_n` = 0 and `rd_stb` = 1 loads `prog_dout` with a threshold, in the same alternating order as writes. The value appears after that edge.
- R9: With `parity_mix_sel` = 1 at reset, a programming word loads {d[16:9], d[7:0]}. Readback drives {0, v[15:8], 0, v[7:0]}, so bits 17 and 8 are 0.
- R10: With `parity_mix_sel` = 0 at reset, a programming word loads d[15:0]. Readback drives {00, v}.
- R11: Changes to `flag_sync_sel` and `parity_mix_sel` after reset have no effect on flag timing or on the word layout.
- R12: Strobes with `prog_n` = 1 neither change a threshold nor advance either alternation, and they leave `prog_dout` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Master reset, active low; configuration is sampled while it is low |
| flag_sync_sel | input | 1 | Flag timing select sampled at reset: 1 synchronous, 0 split-clock |
| parity_mix_sel | input | 1 | Parity layout select sampled at reset: 1 bits 17/8, 0 bits 17/16 |
| prog_n | input | 1 | Top default-index bit during reset; threshold access select (low) after reset |
| dflt_sel | input | 2 | Lower default-index bits sampled at reset |
| wr_stb | input | 1 | Write strobe (wclk domain) |
| rd_stb | input | 1 | Read strobe (rclk domain) |
| prog_din | input | 18 | Threshold programming word |
| wr_ptr | input | AW+1 | Binary write pointer with wrap bit (wclk domain) |
| rd_ptr | input | AW+1 | Binary read pointer with wrap bit (rclk domain) |
| almost_empty | output | 1 | Active high when occupancy <= empty threshold |
| almost_full | output | 1 | Active high when free space <= full threshold |
| prog_dout | output | 18 | Threshold readback word |

## Verification
The bench builds the block with AW = 5, a 32-entry depth. At that size the 7, 15 and 31 defaults land inside the occupancy range, so every occupancy from 0 to 32 can be swept against each of them in both timing modes. The sweeps start from several pointer bases, including bases where the pointers wrap. Both clocks come from one 200 MHz source through separate gates. Stopping either clock shows which edge sets a flag and which edge releases it, and settled levels are deterministic.

// File: rtl/plf_pkg.sv
`timescale 1ns/1ps
package plf_pkg;
  localparam int WORD_W = 18;
  localparam int OFS_W  = 16;

  // default threshold for a reset-time index: 8 << idx, minus one
  function automatic logic [OFS_W-1:0] dflt_offset(input logic [2:0] idx);
    logic [OFS_W:0] span;
    span = (OFS_W+1)'(8) << idx;
    return OFS_W'(span - 1'b1);
  endfunction

  // strip the two parity positions from a programming word
  function automatic logic [OFS_W-1:0] word_to_ofs(input logic [WORD_W-1:0] w,
                                                   input logic mix);
    return mix ? {w[16:9], w[7:0]} : w[15:0];
  endfunction

  // place a threshold back into a word, parity positions driven 0
  function automatic logic [WORD_W-1:0] ofs_to_word(input logic [OFS_W-1:0] v,
                                                    input logic mix);
    return mix ? {1'b0, v[15:8], 1'b0, v[7:0]} : {2'b00, v};
  endfunction

  function automatic logic level_at_or_below(input logic [31:0] lvl,
                                             input logic [OFS_W-1:0] ofs);
    return lvl <= {{(32-OFS_W){1'b0}}, ofs};
  endfunction
endpackage

// File: rtl/plf_ptr_sync.sv
`timescale 1ns/1ps
module plf_ptr_sync #(
  parameter int W      = 11,
  parameter int STAGES = 2
) (
  input  logic         src_clk,
  input  logic         dst_clk,
  input  logic         rst_n,
  input  logic [W-1:0] src_bin,
  output logic [W-1:0] dst_bin
);
  logic [W-1:0]             src_gray;
  logic [STAGES-1:0][W-1:0] pipe;

  function automatic logic [W-1:0] gray_to_bin(input logic [W-1:0] g);
    logic [W-1:0] b;
    b[W-1] = g[W-1];
    for (int i = W-2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) src_gray <= '0;
    else        src_gray <= src_bin ^ (src_bin >> 1);
  end

  always_ff @(posedge dst_clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else begin
      pipe[0] <= src_gray;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign dst_bin = gray_to_bin(pipe[STAGES-1]);
endmodule

// File: rtl/plf_level_view.sv
`timescale 1ns/1ps
module plf_level_view
  import plf_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic [AW:0]      wp,
  input  logic [AW:0]      rp,
  input  logic [OFS_W-1:0] low_ofs,
  input  logic [OFS_W-1:0] high_ofs,
  output logic             low_hit,
  output logic             high_hit
);
  localparam logic [31:0] DEPTH = 32'(1) << AW;

  logic [AW:0] occ;
  logic [31:0] occ32;
  logic [31:0] free32;

  assign occ    = wp - rp;
  assign occ32  = 32'(occ);
  assign free32 = DEPTH - occ32;

  assign low_hit  = level_at_or_below(occ32, low_ofs);
  assign high_hit = level_at_or_below(free32, high_ofs);
endmodule

// File: rtl/plf_edge_flag.sv
`timescale 1ns/1ps
module plf_edge_flag #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic set_clk,
  input  logic clr_clk,
  input  logic rst_n,
  input  logic sync_mode,
  input  logic hit_set,   // condition seen from the setting domain
  input  logic hit_clr,   // condition seen from the releasing domain
  output logic flag
);
  logic q_sync;
  logic set_tog;
  logic clr_tog;
  logic flag_split;

  assign flag_split = set_tog ^ clr_tog;

  always_ff @(posedge set_clk or negedge rst_n) begin
    if (!rst_n) q_sync <= RST_VAL;
    else        q_sync <= hit_set;
  end

  always_ff @(posedge set_clk or negedge rst_n) begin
    if (!rst_n) set_tog <= RST_VAL;
    else if (!sync_mode && hit_set && !flag_split) set_tog <= ~set_tog;
  end

  always_ff @(posedge clr_clk or negedge rst_n) begin
    if (!rst_n) clr_tog <= 1'b0;
    else if (!sync_mode && !hit_clr && flag_split) clr_tog <= ~clr_tog;
  end

  assign flag = sync_mode ? q_sync : flag_split;
endmodule

// File: rtl/plf_offset_bank.sv
`timescale 1ns/1ps
module plf_offset_bank
  import plf_pkg::*;
(
  input  logic              wclk,
  input  logic              rclk,
  input  logic              mrst_n,
  input  logic              flag_sync_sel,
  input  logic              parity_mix_sel,
  input  logic              prog_n,
  input  logic [1:0]        dflt_sel,
  input  logic              wr_stb,
  input  logic              rd_stb,
  input  logic [WORD_W-1:0] prog_din,
  output logic [OFS_W-1:0]  empty_ofs,
  output logic [OFS_W-1:0]  full_ofs,
  output logic              sync_q,
  output logic              mix_q,
  output logic [WORD_W-1:0] prog_dout,
  output logic              wr_sel,
  output logic              rd_sel,
  output logic              prog_wr_evt,
  output logic              prog_rd_evt
);
  localparam int NREG = 2;

  logic [OFS_W-1:0] ofs_q [NREG];
  logic [2:0]       dflt_idx;

  assign dflt_idx    = {prog_n, dflt_sel};
  assign prog_wr_evt = mrst_n && !prog_n && wr_stb;
  assign prog_rd_evt = mrst_n && !prog_n && rd_stb;

  // reset-time sampling of configuration and default thresholds
  always_ff @(posedge wclk) begin
    if (!mrst_n) begin
      sync_q <= flag_sync_sel;
      mix_q  <= parity_mix_sel;
    end
  end

  always_ff @(posedge wclk) begin
    for (int i = 0; i < NREG; i++) begin
      if (!mrst_n)
        ofs_q[i] <= dflt_offset(dflt_idx);
      else if (prog_wr_evt && (wr_sel == 1'(i)))
        ofs_q[i] <= word_to_ofs(prog_din, mix_q);
    end
  end

  always_ff @(posedge wclk or negedge mrst_n) begin
    if (!mrst_n)          wr_sel <= 1'b0;
    else if (prog_wr_evt) wr_sel <= ~wr_sel;
  end

  always_ff @(posedge rclk or negedge mrst_n) begin
    if (!mrst_n) begin
      rd_sel    <= 1'b0;
      prog_dout <= '0;
    end else if (prog_rd_evt) begin
      rd_sel    <= ~rd_sel;
      prog_dout <= ofs_to_word(ofs_q[rd_sel], mix_q);
    end
  end

  assign empty_ofs = ofs_q[0];
  assign full_ofs  = ofs_q[1];
endmodule

// File: rtl/prog_level_flags.sv
`timescale 1ns/1ps
module prog_level_flags
  import plf_pkg::*;
#(
  parameter int AW         = 10,
  parameter int SYNC_STAGE = 2
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          mrst_n,
  input  logic          flag_sync_sel,
  input  logic          parity_mix_sel,
  input  logic          prog_n,
  input  logic [1:0]    dflt_sel,
  input  logic          wr_stb,
  input  logic          rd_stb,
  input  logic [17:0]   prog_din,
  input  logic [AW:0]   wr_ptr,
  input  logic [AW:0]   rd_ptr,
  output logic          almost_empty,
  output logic          almost_full,
  output logic [17:0]   prog_dout
);
  localparam int PW = AW + 1;

  logic [OFS_W-1:0] empty_ofs;
  logic [OFS_W-1:0] full_ofs;
  logic             sync_q;
  logic             mix_q;
  logic             wr_sel;
  logic             rd_sel;
  logic             prog_wr_evt;
  logic             prog_rd_evt;

  logic [PW-1:0]    wp_at_r;
  logic [PW-1:0]    rp_at_w;

  // named events for the checker
  logic ae_hit_rd;   // read view: almost-empty condition
  logic af_hold_rd;  // read view: almost-full condition
  logic ae_hold_wr;  // write view: almost-empty condition
  logic af_hit_wr;   // write view: almost-full condition

  plf_offset_bank i_bank (
    .wclk          (wclk),
    .rclk          (rclk),
    .mrst_n        (mrst_n),
    .flag_sync_sel (flag_sync_sel),
    .parity_mix_sel(parity_mix_sel),
    .prog_n        (prog_n),
    .dflt_sel      (dflt_sel),
    .wr_stb        (wr_stb),
    .rd_stb        (rd_stb),
    .prog_din      (prog_din),
    .empty_ofs     (empty_ofs),
    .full_ofs      (full_ofs),
    .sync_q        (sync_q),
    .mix_q         (mix_q),
    .prog_dout     (prog_dout),
    .wr_sel        (wr_sel),
    .rd_sel        (rd_sel),
    .prog_wr_evt   (prog_wr_evt),
    .prog_rd_evt   (prog_rd_evt)
  );

  plf_ptr_sync #(.W(PW), .STAGES(SYNC_STAGE)) i_w2r (
    .src_clk(wclk), .dst_clk(rclk), .rst_n(mrst_n),
    .src_bin(wr_ptr), .dst_bin(wp_at_r)
  );

  plf_ptr_sync #(.W(PW), .STAGES(SYNC_STAGE)) i_r2w (
    .src_clk(rclk), .dst_clk(wclk), .rst_n(mrst_n),
    .src_bin(rd_ptr), .dst_bin(rp_at_w)
  );

  plf_level_view #(.AW(AW)) i_view_rd (
    .wp(wp_at_r), .rp(rd_ptr), .low_ofs(empty_ofs), .high_ofs(full_ofs),
    .low_hit(ae_hit_rd), .high_hit(af_hold_rd)
  );

  plf_level_view #(.AW(AW)) i_view_wr (
    .wp(wr_ptr), .rp(rp_at_w), .low_ofs(empty_ofs), .high_ofs(full_ofs),
    .low_hit(ae_hold_wr), .high_hit(af_hit_wr)
  );

  plf_edge_flag #(.RST_VAL(1'b1)) i_ae (
    .set_clk(rclk), .clr_clk(wclk), .rst_n(mrst_n), .sync_mode(sync_q),
    .hit_set(ae_hit_rd), .hit_clr(ae_hold_wr), .flag(almost_empty)
  );

  plf_edge_flag #(.RST_VAL(1'b0)) i_af (
    .set_clk(wclk), .clr_clk(rclk), .rst_n(mrst_n), .sync_mode(sync_q),
    .hit_set(af_hit_wr), .hit_clr(af_hold_rd), .flag(almost_full)
  );
endmodule

// File: rtl/plf_checker.sv
`timescale 1ns/1ps
module plf_checker (
  input logic        wclk,
  input logic        rclk,
  input logic        mrst_n,
  input logic        sync_q,
  input logic        mix_q,
  input logic        ae_hit_rd,
  input logic        af_hit_wr,
  input logic        almost_empty,
  input logic        almost_full,
  input logic        prog_wr_evt,
  input logic        wr_sel,
  input logic [17:0] prog_dout
);
  logic w_ok;
  logic r_ok;

  always_ff @(posedge wclk or negedge mrst_n) begin
    if (!mrst_n) w_ok <= 1'b0;
    else         w_ok <= 1'b1;
  end

  always_ff @(posedge rclk or negedge mrst_n) begin
    if (!mrst_n) r_ok <= 1'b0;
    else         r_ok <= 1'b1;
  end

  assert_ae_sync_rclk_R5: assert property (@(posedge rclk) disable iff (!mrst_n)
    (r_ok && sync_q) |-> (almost_empty == $past(ae_hit_rd)));

  assert_af_sync_wclk_R5: assert property (@(posedge wclk) disable iff (!mrst_n)
    (w_ok && sync_q) |-> (almost_full == $past(af_hit_wr)));

  assert_wr_alternates_R7: assert property (@(posedge wclk) disable iff (!mrst_n)
    (w_ok && prog_wr_evt) |=> (wr_sel != $past(wr_sel)));

  assert_mix_parity_zero_R9: assert property (@(posedge rclk) disable iff (!mrst_n)
    (r_ok && mix_q) |-> (prog_dout[17] == 1'b0 && prog_dout[8] == 1'b0));

  assert_plain_parity_zero_R10: assert property (@(posedge rclk) disable iff (!mrst_n)
    (r_ok && !mix_q) |-> (prog_dout[17:16] == 2'b00));

  assert_cfg_held_R11: assert property (@(posedge wclk) disable iff (!mrst_n)
    w_ok |-> ($stable(sync_q) && $stable(mix_q)));
endmodule

bind prog_level_flags plf_checker i_plf_checker (
  .wclk        (wclk),
  .rclk        (rclk),
  .mrst_n      (mrst_n),
  .sync_q      (sync_q),
  .mix_q       (mix_q),
  .ae_hit_rd   (ae_hit_rd),
  .af_hit_wr   (af_hit_wr),
  .almost_empty(almost_empty),
  .almost_full (almost_full),
  .prog_wr_evt (prog_wr_evt),
  .wr_sel      (wr_sel),
  .prog_dout   (prog_dout)
);

// File: tb/test_prog_level_flags.sv
`timescale 1ns/1ps
module test_prog_level_flags;
  localparam int AW    = 5;
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam int PMOD  = 1 << PW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic wrun = 1'b1;
  logic rrun = 1'b1;
  logic wclk;
  logic rclk;
  assign wclk = clk & wrun;
  assign rclk = clk & rrun;

  logic          mrst_n = 1'b0;
  logic          flag_sync_sel = 1'b1;
  logic          parity_mix_sel = 1'b0;
  logic          prog_n = 1'b1;
  logic [1:0]    dflt_sel = 2'b00;
  logic          wr_stb = 1'b0;
  logic          rd_stb = 1'b0;
  logic [17:0]   prog_din = '0;
  logic [PW-1:0] wr_ptr = '0;
  logic [PW-1:0] rd_ptr = '0;
  logic          almost_empty;
  logic          almost_full;
  logic [17:0]   prog_dout;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  prog_level_flags #(.AW(AW)) i_prog_level_flags (
    .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n),
    .flag_sync_sel(flag_sync_sel), .parity_mix_sel(parity_mix_sel),
    .prog_n(prog_n), .dflt_sel(dflt_sel), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .prog_din(prog_din), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .almost_empty(almost_empty), .almost_full(almost_full), .prog_dout(prog_dout)
  );

  task automatic chk(input string msg, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  function automatic int dflt_val(input int k);
    int v = 1;
    for (int i = 0; i < k + 3; i++) v = v * 2;
    return v - 1;
  endfunction

  function automatic int exp_load(input int d, input bit mix);
    if (mix) return ((d / 512) % 256) * 256 + (d % 256);
    return d % 65536;
  endfunction

  function automatic int exp_read(input int v, input bit mix);
    if (mix) return ((v / 256) % 256) * 512 + (v % 256);
    return v % 65536;
  endfunction

  task automatic do_reset(input int k, input bit syn, input bit mix);
    @(negedge clk);
    mrst_n = 1'b0;
    prog_n = k[2];
    dflt_sel = k[1:0];
    flag_sync_sel = syn;
    parity_mix_sel = mix;
    wr_ptr = '0;
    rd_ptr = '0;
    wr_stb = 1'b0;
    rd_stb = 1'b0;
    wrun = 1'b1;
    rrun = 1'b1;
    repeat (4) @(negedge clk);
    mrst_n = 1'b1;
    prog_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic set_ptrs(input int w, input int r);
    @(negedge clk);
    wr_ptr = PW'(w);
    rd_ptr = PW'(r);
    repeat (10) @(negedge clk);
  endtask

  task automatic wr_ofs(input int d);
    @(negedge clk);
    prog_n = 1'b0;
    wr_stb = 1'b1;
    prog_din = 18'(d);
    @(negedge clk);
    wr_stb = 1'b0;
    prog_n = 1'b1;
  endtask

  task automatic rd_ofs(output int v);
    @(negedge clk);
    prog_n = 1'b0;
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    prog_n = 1'b1;
    v = int'(prog_dout);
  endtask

  task automatic sweep(input string tag, input int ao, input int fo, input int stride);
    for (int occ = 0; occ <= DEPTH; occ++) begin
      int rp;
      int wp;
      rp = (occ * stride + 3) % PMOD;
      wp = (rp + occ) % PMOD;
      set_ptrs(wp, rp);
      chk($sformatf("R3 %s almost_empty occ=%0d", tag, occ), int'(almost_empty), (occ <= ao) ? 1 : 0);
      chk($sformatf("R4 %s almost_full occ=%0d", tag, occ), int'(almost_full), ((DEPTH - occ) <= fo) ? 1 : 0);
    end
  endtask

  task automatic stop_test(input bit syn, input bit relabel);
    int e;
    do_reset(0, syn, 1'b0);
    if (relabel) begin
      flag_sync_sel = ~syn;
      parity_mix_sel = 1'b1;
    end
    set_ptrs(0, 0);
    chk("R5/R6 almost_empty at zero fill", int'(almost_empty), 1);
    @(negedge clk);
    rrun = 1'b0;
    wr_ptr = PW'(20);
    repeat (10) @(negedge clk);
    e = syn ? 1 : 0;
    if (relabel) chk("R11 almost_empty with rclk stopped", int'(almost_empty), e);
    else if (syn) chk("R5 almost_empty held with rclk stopped", int'(almost_empty), e);
    else chk("R6 almost_empty released by wclk", int'(almost_empty), e);
    rrun = 1'b1;
    repeat (10) @(negedge clk);
    chk("R5/R6 almost_empty after rclk resumes", int'(almost_empty), 0);
    set_ptrs(30, 0);
    chk("R5/R6 almost_full at fill 30", int'(almost_full), 1);
    @(negedge clk);
    wrun = 1'b0;
    rd_ptr = PW'(20);
    repeat (10) @(negedge clk);
    if (relabel) chk("R11 almost_full with wclk stopped", int'(almost_full), e);
    else if (syn) chk("R5 almost_full held with wclk stopped", int'(almost_full), e);
    else chk("R6 almost_full released by rclk", int'(almost_full), e);
    wrun = 1'b1;
    repeat (10) @(negedge clk);
    chk("R5/R6 almost_full after wclk resumes", int'(almost_full), 0);
  endtask

  initial begin
    #(5.0 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    int v;
    // R1 reset state
    @(negedge clk);
    chk("R1 almost_empty during reset", int'(almost_empty), 1);
    chk("R1 almost_full during reset", int'(almost_full), 0);
    chk("R1 prog_dout during reset", int'(prog_dout), 0);
    do_reset(0, 1'b1, 1'b0);
    chk("R1 almost_empty after reset", int'(almost_empty), 1);
    chk("R1 almost_full after reset", int'(almost_full), 0);
    chk("R1 prog_dout after reset", int'(prog_dout), 0);

    // R2 defaults for every index
    for (int k = 0; k < 8; k++) begin
      do_reset(k, 1'b1, 1'b0);
      rd_ofs(v);
      chk($sformatf("R2 empty default k=%0d", k), v, dflt_val(k));
      rd_ofs(v);
      chk($sformatf("R2 full default k=%0d", k), v, dflt_val(k));
    end

    // R3 / R4 sweeps in both timing modes
    for (int m = 0; m < 2; m++) begin
      for (int k = 0; k < 3; k++) begin
        do_reset(k, m[0], 1'b0);
        sweep($sformatf("mode=%0d k=%0d", m, k), dflt_val(k), dflt_val(k), 7 + 2 * k);
      end
    end

    // R7 / R8 alternation
    do_reset(0, 1'b1, 1'b0);
    wr_ofs(10);
    wr_ofs(3);
    rd_ofs(v); chk("R8 first readback is empty threshold", v, 10);
    rd_ofs(v); chk("R8 second readback is full threshold", v, 3);
    rd_ofs(v); chk("R8 readback wraps to empty threshold", v, 10);
    sweep("R7 programmed", 10, 3, 5);
    wr_ofs(12);
    rd_ofs(v); chk("R7 third write went to empty, full kept", v, 3);
    rd_ofs(v); chk("R7 third write lands in empty threshold", v, 12);

    // R9 interspersed parity
    do_reset(0, 1'b0, 1'b1);
    wr_ofs(18'h3FFFF);
    wr_ofs(18'h00105);
    rd_ofs(v); chk("R9 readback of all-ones word", v, exp_read(exp_load(18'h3FFFF, 1'b1), 1'b1));
    rd_ofs(v); chk("R9 readback with bit 8 dropped", v, exp_read(exp_load(18'h00105, 1'b1), 1'b1));
    wr_ofs(18'h00105);
    set_ptrs(5, 0);
    chk("R9 empty threshold 5 at fill 5", int'(almost_empty), 1);
    set_ptrs(6, 0);
    chk("R9 empty threshold 5 at fill 6", int'(almost_empty), 0);

    // R10 plain parity
    do_reset(0, 1'b1, 1'b0);
    wr_ofs(18'h30005);
    wr_ofs(18'h3FFFF);
    rd_ofs(v); chk("R10 bits 17:16 dropped", v, exp_read(exp_load(18'h30005, 1'b0), 1'b0));
    rd_ofs(v); chk("R10 all-ones word", v, exp_read(exp_load(18'h3FFFF, 1'b0), 1'b0));
    set_ptrs(5, 0);
    chk("R10 empty threshold 5 at fill 5", int'(almost_empty), 1);
    set_ptrs(6, 0);
    chk("R10 empty threshold 5 at fill 6", int'(almost_empty), 0);

    // R5 / R6 clock ownership
    stop_test(1'b1, 1'b0);
    stop_test(1'b0, 1'b0);

    // R11 pins changed after reset
    stop_test(1'b1, 1'b1);
    wr_ofs(18'h3FFFF);
    rd_ofs(v); chk("R11 layout still plain after pin change", v, exp_read(exp_load(18'h3FFFF, 1'b0), 1'b0));

    // R12 strobes with prog_n high
    do_reset(0, 1'b1, 1'b0);
    wr_ofs(9);
    @(negedge clk);
    prog_din = 18'd100;
    wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
    wr_ofs(4);
    rd_ofs(v); chk("R12 empty threshold untouched", v, 9);
    @(negedge clk);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    chk("R12 prog_dout unchanged by ignored read", int'(prog_dout), 9);
    rd_ofs(v); chk("R12 read order not advanced", v, 4);
    rd_ofs(v); chk("R12 empty threshold still 9", v, 9);

    summary();
  end
endmodule